// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked system read and write an external asynchronous static RAM that holds 128K bytes. A requester presents an address, a read/write flag and, for writes, one data byte. It holds them with `req_valid` until the block answers with a one-cycle `req_ack`. For a read, the byte comes back on `req_rdata` in the same cycle as the acknowledge.

On the memory side the block drives a 17-bit address and two chip selects of opposite polarity. It also drives the output-enable and write-enable strobes. The 8-bit data bus is shared, so the block keeps its own drivers off through a separate enable until the memory has had time to release the bus. The memory has no clock. Every timing limit is met by holding each phase for a whole number of clock cycles. Each count is the ceiling of a nanosecond parameter divided by the clock period, and is never less than one. While no access is running, the memory stays deselected. A standby input stops any new access from starting.

Top module: `sram_async_ctrl`

## Requirements
- R1: During reset and while idle, `mem_cs_n`=1, `mem_cs`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0 and `req_ack`=0.
- R2: The memory is selected only with `mem_cs_n`=0 and `mem_cs`=1. The two chip selects are always of opposite value, and they are asserted only while an access runs.
- R3: A read holds `mem_we_n`=1 and `mem_oe_n`=0 with the memory selected. It returns on `req_rdata` the byte stored at the address, and `req_rdata` changes only when a read completes.
- R4: The read data is sampled RD_CYC = max(ceil(access_ns/T), ceil(cycle_ns/T)) clock edges after the address and strobes are launched. With the defaults this is 7 cycles, so `req_ack` is seen RD_CYC+1 cycles after the request is raised.
- R5: A write holds `mem_we_n`=0 with the memory selected and `mem_oe_n`=1 for exactly WR_CYC = max(ceil(pulse_ns/T), TA_CYC+DS_CYC, ceil(cycle_ns/T)) cycles. With the defaults this is 7. The memory then stores `req_wdata` at the address, and `req_ack` is seen WR_CYC+1 cycles after the request is raised.
- R6: The write data is driven and stable for at least DS_CYC = ceil(setup_ns/T) cycles before `mem_we_n` rises, and `mem_dq_oe` drops at the same edge at which `mem_we_n` rises.
- R7: `mem_dq_oe` stays 0 for TA_CYC = ceil(release_ns/T) cycles after `mem_we_n` falls, and it is never 1 outside the write pulse.
- R8: `mem_addr` is stable for the whole time the memory is selected.
- R9: `req_ack` is high for exactly one cycle per access, and a request that is still held in its acknowledge cycle is not started a second time.
- R10: While `standby_req`=1, no access starts and the memory stays deselected. A pending request is served once `standby_req` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| standby_req | input | 1 | Stops new accesses from starting; the memory stays deselected |
| req_valid | input | 1 | Request held high until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| req_rdata | output | 8 | Read data, valid with req_ack on reads |
| mem_addr | output | 17 | Memory address |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Data toward memory |
| mem_dq_oe | output | 1 | Enable for the block's own data drivers |
| mem_dq_in | input | 8 | Data from memory |

## Verification
The assertions assume that a requester keeps `req_valid` and its fields steady until `req_ack` and drops the request in the acknowledge cycle. They also assume that `standby_req` changes only between clock edges. The bench holds to both by driving every input on the falling clock edge and by releasing the request in the same half-cycle in which it sees the acknowledge. The memory model in the bench drives real data only once the access count has elapsed, and it returns inverted data before that. It also treats the bus as its own for the release window after a write strobe falls. Because of this, early sampling, a short pulse or an early driver enable each show up as wrong data or a model violation at the ports.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } ctrl_state_e;

    // Whole clock cycles covering a nanosecond limit, never below one.
    function automatic int ns_to_cycles(input int lim_ns, input int period_ns);
        int c;
        c = (lim_ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic [TW-1:0] cnt,
    output logic          zero
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt  = cnt_q;
    assign zero = (cnt_q == '0);

    AST_TMR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && zero) |=> zero); // R4

endmodule

// File: rtl/sram_dq_port.sv
module sram_dq_port #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wdata_load,
    input  logic [DW-1:0] wdata_in,
    input  logic          capture,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] dq_out,
    output logic [DW-1:0] rdata
);
    typedef struct packed {
        logic [DW-1:0] wbuf;
        logic [DW-1:0] rbuf;
    } port_regs_t;

    port_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wdata_load) r_d.wbuf = wdata_in;
        if (capture)    r_d.rbuf = dq_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dq_out = r_q.wbuf;
    assign rdata  = r_q.rbuf;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(rdata)); // R3

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int AW     = 17,
    parameter int TW     = 4,
    parameter int RD_CYC = 7,
    parameter int WR_CYC = 7,
    parameter int TA_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          standby_req,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [TW-1:0] tmr_cnt,
    input  logic          tmr_zero,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          wdata_load,
    output logic          capture,
    output logic          req_ack,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs_n,
    output logic          mem_cs,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic          mem_dq_oe
);
    localparam logic [TW-1:0] RD_LOAD  = TW'(RD_CYC - 1);
    localparam logic [TW-1:0] WR_LOAD  = TW'(WR_CYC - 1);
    localparam logic [TW-1:0] DRV_MARK = TW'(WR_CYC - TA_CYC);

    typedef struct packed {
        ctrl_state_e   state;
        logic [AW-1:0] addr;
        logic          cs_n;
        logic          cs;
        logic          we_n;
        logic          oe_n;
        logic          dq_oe;
        logic          ack;
    } ctrl_regs_t;

    localparam ctrl_regs_t REGS_RST = '{
        state: ST_IDLE, addr: '0, cs_n: 1'b1, cs: 1'b0,
        we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0, ack: 1'b0
    };

    ctrl_regs_t r_d, r_q;
    logic       accept;

    assign accept = (r_q.state == ST_IDLE) && req_valid && !standby_req && !r_q.ack;

    always_comb begin
        r_d        = r_q;
        r_d.ack    = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = req_write ? WR_LOAD : RD_LOAD;
        wdata_load = 1'b0;
        capture    = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (accept) begin
                    r_d.addr = req_addr;
                    r_d.cs_n = 1'b0;
                    r_d.cs   = 1'b1;
                    tmr_load = 1'b1;
                    if (req_write) begin
                        r_d.we_n   = 1'b0;
                        r_d.state  = ST_WRITE;
                        wdata_load = 1'b1;
                    end else begin
                        r_d.oe_n  = 1'b0;
                        r_d.state = ST_READ;
                    end
                end
            end
            ST_READ: begin
                if (tmr_zero) begin
                    capture   = 1'b1;
                    r_d.ack   = 1'b1;
                    r_d.cs_n  = 1'b1;
                    r_d.cs    = 1'b0;
                    r_d.oe_n  = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            ST_WRITE: begin
                if (tmr_cnt == DRV_MARK) r_d.dq_oe = 1'b1;
                if (tmr_zero) begin
                    r_d.we_n  = 1'b1;
                    r_d.dq_oe = 1'b0;
                    r_d.ack   = 1'b1;
                    r_d.cs_n  = 1'b1;
                    r_d.cs    = 1'b0;
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign req_ack   = r_q.ack;
    assign mem_addr  = r_q.addr;
    assign mem_cs_n  = r_q.cs_n;
    assign mem_cs    = r_q.cs;
    assign mem_we_n  = r_q.we_n;
    assign mem_oe_n  = r_q.oe_n;
    assign mem_dq_oe = r_q.dq_oe;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE) |-> (mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe)); // R1
    AST_CS_OPPOSED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_n != mem_cs); // R2
    AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n)); // R3
    AST_RELEASE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !mem_dq_oe); // R6
    AST_TA_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> !mem_dq_oe); // R7
    AST_DRV_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && mem_oe_n && !mem_cs_n)); // R7
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr)); // R8
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack); // R9
    AST_STANDBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (standby_req && r_q.state == ST_IDLE) |=> mem_cs_n); // R10

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int AW        = 17,
    parameter int DW        = 8,
    parameter int CLK_NS    = 5,
    parameter int ACCESS_NS = 35,
    parameter int CYCLE_NS  = 35,
    parameter int PULSE_NS  = 25,
    parameter int SETUP_NS  = 20,
    parameter int RELEASE_NS = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          standby_req,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ack,
    output logic [DW-1:0] req_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs_n,
    output logic          mem_cs,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    localparam int ACC_CYC = ns_to_cycles(ACCESS_NS, CLK_NS);
    localparam int CYC_CYC = ns_to_cycles(CYCLE_NS, CLK_NS);
    localparam int WP_CYC  = ns_to_cycles(PULSE_NS, CLK_NS);
    localparam int DS_CYC  = ns_to_cycles(SETUP_NS, CLK_NS);
    localparam int TA_CYC  = ns_to_cycles(RELEASE_NS, CLK_NS);
    localparam int RD_CYC  = max2(ACC_CYC, CYC_CYC);
    localparam int WR_CYC  = max2(WP_CYC, max2(TA_CYC + DS_CYC, CYC_CYC));
    localparam int TW      = $clog2(max2(RD_CYC, WR_CYC) + 1);

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic [TW-1:0] tmr_cnt;
    logic          tmr_zero;
    logic          wdata_load;
    logic          capture;

    sram_phase_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .cnt      (tmr_cnt),
        .zero     (tmr_zero)
    );

    sram_ctrl_fsm #(
        .AW     (AW),
        .TW     (TW),
        .RD_CYC (RD_CYC),
        .WR_CYC (WR_CYC),
        .TA_CYC (TA_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .standby_req (standby_req),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .tmr_cnt     (tmr_cnt),
        .tmr_zero    (tmr_zero),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .wdata_load  (wdata_load),
        .capture     (capture),
        .req_ack     (req_ack),
        .mem_addr    (mem_addr),
        .mem_cs_n    (mem_cs_n),
        .mem_cs      (mem_cs),
        .mem_we_n    (mem_we_n),
        .mem_oe_n    (mem_oe_n),
        .mem_dq_oe   (mem_dq_oe)
    );

    sram_dq_port #(.DW(DW)) u_dq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wdata_load (wdata_load),
        .wdata_in   (req_wdata),
        .capture    (capture),
        .dq_in      (mem_dq_in),
        .dq_out     (mem_dq_out),
        .rdata      (req_rdata)
    );

endmodule

// File: tb/sram_async_ctrl_bench.sv
module sram_async_ctrl_bench;

    localparam int T_NS   = 5;
    localparam int ACC    = (35 + T_NS - 1) / T_NS;
    localparam int CYC    = (35 + T_NS - 1) / T_NS;
    localparam int WP     = (25 + T_NS - 1) / T_NS;
    localparam int DS     = (20 + T_NS - 1) / T_NS;
    localparam int TA     = (10 + T_NS - 1) / T_NS;
    localparam int RD_EXP = (ACC > CYC) ? ACC : CYC;
    localparam int WR_A   = (WP > TA + DS) ? WP : TA + DS;
    localparam int WR_EXP = (WR_A > CYC) ? WR_A : CYC;
    localparam int NADDR  = 169;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby_req = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ack;
    logic [7:0]  req_rdata;
    logic [16:0] mem_addr;
    logic        mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    sram_async_ctrl u_sram_async_ctrl (
        .clk (clk), .rst_n (rst_n), .standby_req (standby_req),
        .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
        .req_wdata (req_wdata), .req_ack (req_ack), .req_rdata (req_rdata),
        .mem_addr (mem_addr), .mem_cs_n (mem_cs_n), .mem_cs (mem_cs),
        .mem_we_n (mem_we_n), .mem_oe_n (mem_oe_n), .mem_dq_out (mem_dq_out),
        .mem_dq_oe (mem_dq_oe), .mem_dq_in (mem_dq_in)
    );

    // Behavioural memory with cycle-count timing checks.
    logic [7:0]  mem [0:131071];
    int          wl_cnt, ds_cnt, acc_cnt, viol, last_pulse, last_setup;
    logic [16:0] wl_addr, rd_addr;
    logic [7:0]  wl_data, ds_data;
    logic        wl_drv;
    wire sel   = !mem_cs_n && mem_cs;
    wire rd_on = sel && mem_we_n && !mem_oe_n;
    wire wr_on = sel && !mem_we_n;

    assign mem_dq_in = !rd_on ? 8'h00 :
                       (acc_cnt >= ACC - 1) ? mem[mem_addr] : ~mem[mem_addr];

    initial begin
        for (int i = 0; i < 131072; i++) mem[i] = 8'h00;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            wl_cnt <= 0; ds_cnt <= 0; acc_cnt <= 0; viol <= 0;
            last_pulse <= 0; last_setup <= 0; wl_drv <= 1'b0;
            wl_addr <= '0; wl_data <= '0; ds_data <= '0; rd_addr <= '0;
        end else begin
            if (wr_on) begin
                wl_cnt  <= wl_cnt + 1;
                wl_addr <= mem_addr;
                wl_data <= mem_dq_out;
                wl_drv  <= mem_dq_oe;
                if (wl_cnt != 0 && mem_addr != wl_addr) viol <= viol + 1;   // R8
                if (mem_dq_oe && wl_cnt < TA) viol <= viol + 1;             // R7
                if (mem_dq_oe) begin
                    ds_cnt  <= (ds_cnt != 0 && mem_dq_out != ds_data) ? 1 : ds_cnt + 1;
                    ds_data <= mem_dq_out;
                end else begin
                    ds_cnt <= 0;
                end
            end else begin
                if (wl_cnt != 0) begin
                    last_pulse <= wl_cnt;
                    last_setup <= ds_cnt;
                    if (wl_drv) mem[wl_addr] <= wl_data;
                    else        viol <= viol + 1;                           // R6
                end
                if (mem_dq_oe) viol <= viol + 1;                            // R7
                wl_cnt <= 0;
                ds_cnt <= 0;
            end
            if (rd_on) begin
                rd_addr <= mem_addr;
                acc_cnt <= (acc_cnt != 0 && mem_addr != rd_addr) ? 0 : acc_cnt + 1;
            end else begin
                acc_cnt <= 0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input logic [16:0] a);
        return a[7:0] ^ a[15:8] ^ {a[16], 7'h35};
    endfunction

    task automatic run_op(input logic wr, input logic [16:0] a, input logic [7:0] d,
                          output logic [7:0] rd, output int lat);
        lat = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        do begin
            @(negedge clk);
            lat++;
        end while (!req_ack && lat < 64);
        rd = req_rdata;
        req_valid = 1'b0;
        @(negedge clk);
        check(req_ack == 1'b0, "R9 ack single cycle", int'(req_ack), 0);
    endtask

    logic [16:0] addrs [0:NADDR-1];

    initial begin
        logic [16:0] s;
        logic [7:0]  rd;
        int          lat;
        bit          ok;
        repeat (4) @(negedge clk);
        check(mem_cs_n == 1'b1, "R1 cs_n idle", int'(mem_cs_n), 1);
        check(mem_cs == 1'b0, "R1 cs idle", int'(mem_cs), 0);
        check(mem_we_n == 1'b1, "R1 we_n idle", int'(mem_we_n), 1);
        check(mem_oe_n == 1'b1, "R1 oe_n idle", int'(mem_oe_n), 1);
        check(mem_dq_oe == 1'b0, "R1 dq_oe idle", int'(mem_dq_oe), 0);
        check(req_ack == 1'b0, "R1 ack idle", int'(req_ack), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_cs_n == 1'b1 && mem_cs == 1'b0, "R2 deselected after reset", int'(mem_cs), 0);

        addrs[0] = 17'h00000;
        addrs[1] = 17'h1FFFF;
        for (int i = 0; i < 17; i++) addrs[2 + i] = 17'(1) << i;
        s = 17'h1ACE1;
        for (int i = 19; i < NADDR; i++) begin
            s = {s[15:0], s[16] ^ s[13]};
            addrs[i] = s;
        end

        for (int i = 0; i < NADDR; i++) begin
            run_op(1'b1, addrs[i], pat(addrs[i]), rd, lat);
            check(lat == WR_EXP + 1, "R5 write ack latency", lat, WR_EXP + 1);
            check(last_pulse == WR_EXP, "R5 write pulse cycles", last_pulse, WR_EXP);
            check(last_setup >= DS, "R6 data setup cycles", last_setup, DS);
            check(viol == 0, "R7 R8 bus and address rules", viol, 0);
        end
        for (int i = 0; i < NADDR; i++) begin
            run_op(1'b0, addrs[i], 8'h00, rd, lat);
            check(rd == pat(addrs[i]), "R3 R4 read data", int'(rd), int'(pat(addrs[i])));
            check(lat == RD_EXP + 1, "R4 read ack latency", lat, RD_EXP + 1);
        end
        // Read-after-overwrite on a corner address
        run_op(1'b1, 17'h1FFFF, 8'hC3, rd, lat);
        run_op(1'b0, 17'h1FFFF, 8'h00, rd, lat);
        check(rd == 8'hC3, "R5 overwrite stored", int'(rd), 8'hC3);

        // Standby holds the request off
        @(negedge clk);
        standby_req = 1'b1;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h00000;
        ok = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (req_ack || !mem_cs_n || mem_cs) ok = 1'b0;
        end
        check(ok, "R10 no access while in standby", int'(ok), 1);
        standby_req = 1'b0;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!req_ack && lat < 64);
        check(req_rdata == pat(17'h0), "R10 served after standby", int'(req_rdata), int'(pat(17'h0)));
        check(lat == RD_EXP + 1, "R10 latency after standby", lat, RD_EXP + 1);
        req_valid = 1'b0;
        @(negedge clk);
        check(req_ack == 1'b0 && mem_cs_n, "R9 no re-accept", int'(req_ack), 0);
        check(viol == 0, "R7 R8 final model violations", viol, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait (cycles >= 150000);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule